// File: doc/BRIEF.md
# Embedded-Clock Serial Framer

This block turns a stream of 18-bit parallel words into a serial bit stream that carries its own timing. Each word is wrapped in a 20-bit frame: a leading clock bit of 1, the eighteen payload bits with the least significant bit first, and a trailing clock bit of 0. As a result every frame boundary holds exactly one rising edge, which a far-end receiver uses to recover the word clock. The frame goes out one bit per pulse of a bit-rate clock enable, `bit_en`, which the surrounding clocking logic supplies.

A host can assert `sync_req` to replace the payload with a fixed training word. That word gives the receiver a frame with no rising edge other than the one at the boundary, so the receiver locks quickly and after a predictable delay.

Several controls set the state of the output. A low-power input stops framing completely. After that input returns high, framing waits until the clock source reports ready. A separate output-enable floats only the serial driver and leaves the framing running. A local-loopback mode also floats the driver. The serial pin is modelled as a data bit, `ser_bit`, plus a drive enable, `ser_oe`. When `ser_oe` is low, the pad is at high impedance.

Top module: `ecs_framer`

## Requirements
- R1: Each frame lasts 20 `bit_en` ticks and is sent in this order: bit 0 is a 1, bits 1 to 18 are `word_in[0]` to `word_in[17]`, and bit 19 is a 0. Each bit appears on `ser_bit` in the clock cycle that follows the edge where `bit_en` was sampled high.
- R2: `word_in` and `sync_req` are sampled only on the tick that sends bit 0 of a frame. `word_taken` is high for exactly that one cycle. A change to `word_in` in the middle of a frame does not alter the frame being sent.
- R3: When `sync_req` is high at a frame start, the payload is the training word 18'h001FF: nine 1s sent first, then nine 0s. The only 0-to-1 transition in the stream then falls at the frame boundary.
- R4: While `awake` is low, `ser_oe` is low. From the next edge onward, `ser_bit` is 0 and `word_taken` is 0. A partly sent frame is abandoned.
- R5: After `awake` rises, no frame starts until `clk_ready` has been seen high. Framing then resumes on a frame boundary, and the next tick sends bit 0 of a new frame.
- R6: While `oe` is low, `ser_oe` is low. Framing continues unaffected, so when `oe` returns high the stream carries on from the same bit position.
- R7: While `loop_local` is high, `ser_oe` is low. Framing continues unaffected.
- R8: After reset, `ser_oe`, `ser_bit` and `word_taken` are all 0.
- R9: `ser_bit` changes only on an edge where `bit_en` is high, or when framing is stopped by `awake` going low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| bit_en | input | 1 | Bit-rate clock enable, one pulse per serial bit |
| word_in | input | 18 | Parallel payload word |
| sync_req | input | 1 | Send the training frame instead of payload |
| awake | input | 1 | Low selects the low-power stopped state |
| clk_ready | input | 1 | Clock source ready indication |
| oe | input | 1 | Serial output enable; low floats the driver |
| loop_local | input | 1 | Local-loopback mode; floats the driver |
| ser_bit | output | 1 | Serial data bit |
| ser_oe | output | 1 | Serial driver enable; low means high impedance |
| word_taken | output | 1 | One-cycle pulse when a frame starts |

## Verification
Two pairs of functions can act in the same cycle. The first pair is the word capture at a frame boundary and a change of `word_in` (or `sync_req`). The bench changes the word in the middle of a frame, right after a tick, and checks that the current frame carries the old word and the next frame carries the new one. The second pair is an output float (from `oe` or `loop_local`) and the shifting that continues underneath it. The bench floats the driver across several ticks in the middle of a frame, checks that `ser_oe` is low in exactly those ticks, and checks that the twenty collected bits still form the correct frame.

// File: rtl/ecs_pkg.sv
package ecs_pkg;

    localparam int WORD_W_DEF = 18;

    typedef enum logic [1:0] {
        PWR_OFF  = 2'd0,
        PWR_WAIT = 2'd1,
        PWR_RUN  = 2'd2
    } pwr_state_t;

    typedef struct packed {
        logic                  tail;   // trailing clock bit, sent last
        logic [WORD_W_DEF-1:0] body;   // payload, LSB sent first
        logic                  head;   // leading clock bit, sent first
    } frame_t;

    localparam logic HEAD_BIT = 1'b1;
    localparam logic TAIL_BIT = 1'b0;

endpackage

// File: rtl/ecs_pwr_ctl.sv
module ecs_pwr_ctl
    import ecs_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic awake,
    input  logic clk_ready,
    output logic run
);

    pwr_state_t state_q, state_d;

    always_comb begin
        state_d = state_q;
        if (!awake) begin
            state_d = PWR_OFF;
        end else begin
            case (state_q)
                PWR_OFF:  state_d = PWR_WAIT;
                PWR_WAIT: state_d = clk_ready ? PWR_RUN : PWR_WAIT;
                PWR_RUN:  state_d = PWR_RUN;
                default:  state_d = PWR_OFF;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= PWR_OFF;
        else     state_q <= state_d;
    end

    assign run = (state_q == PWR_RUN) && awake;

endmodule

// File: rtl/ecs_frame_build.sv
module ecs_frame_build
    import ecs_pkg::*;
#(
    parameter int WORD_W  = WORD_W_DEF,
    localparam int FRAME_W = WORD_W + 2
) (
    input  logic [WORD_W-1:0]  word_in,
    input  logic               sync_req,
    output logic [FRAME_W-1:0] frame
);

    localparam int HALF_W = WORD_W / 2;

    logic [WORD_W-1:0] train_word;
    logic [WORD_W-1:0] body;

    // training word: first half of the payload ones, remainder zeros
    generate
        for (genvar g = 0; g < WORD_W; g++) begin : g_train
            if (g < HALF_W) begin : g_one
                assign train_word[g] = 1'b1;
            end else begin : g_zero
                assign train_word[g] = 1'b0;
            end
        end
    endgenerate

    assign body  = sync_req ? train_word : word_in;
    assign frame = {TAIL_BIT, body, HEAD_BIT};

endmodule

// File: rtl/ecs_shifter.sv
module ecs_shifter #(
    parameter int FRAME_W = 20,
    localparam int CNT_W  = $clog2(FRAME_W)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               run,
    input  logic               bit_en,
    input  logic [FRAME_W-1:0] frame_in,
    output logic               ser_bit,
    output logic               take
);

    localparam logic [CNT_W-1:0] LAST_POS = CNT_W'(FRAME_W - 1);

    logic [CNT_W-1:0]   pos_q;
    logic [FRAME_W-1:0] shreg_q;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            pos_q   <= '0;
            shreg_q <= '0;
            ser_bit <= 1'b0;
            take    <= 1'b0;
        end else begin
            take <= 1'b0;
            if (bit_en) begin
                if (pos_q == '0) begin
                    ser_bit <= frame_in[0];
                    shreg_q <= frame_in >> 1;
                    take    <= 1'b1;
                    pos_q   <= CNT_W'(1);
                end else begin
                    ser_bit <= shreg_q[0];
                    shreg_q <= shreg_q >> 1;
                    pos_q   <= (pos_q == LAST_POS) ? '0 : pos_q + CNT_W'(1);
                end
            end
        end
    end

endmodule

// File: rtl/ecs_framer.sv
module ecs_framer
    import ecs_pkg::*;
#(
    parameter int WORD_W  = WORD_W_DEF,
    localparam int FRAME_W = WORD_W + 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bit_en,
    input  logic [WORD_W-1:0] word_in,
    input  logic              sync_req,
    input  logic              awake,
    input  logic              clk_ready,
    input  logic              oe,
    input  logic              loop_local,
    output logic              ser_bit,
    output logic              ser_oe,
    output logic              word_taken
);

    logic               run;
    logic [FRAME_W-1:0] next_frame;

    ecs_pwr_ctl u_pwr (
        .clk       (clk),
        .rst       (rst),
        .awake     (awake),
        .clk_ready (clk_ready),
        .run       (run)
    );

    ecs_frame_build #(.WORD_W(WORD_W)) u_build (
        .word_in  (word_in),
        .sync_req (sync_req),
        .frame    (next_frame)
    );

    ecs_shifter #(.FRAME_W(FRAME_W)) u_shift (
        .clk      (clk),
        .rst      (rst),
        .run      (run),
        .bit_en   (bit_en),
        .frame_in (next_frame),
        .ser_bit  (ser_bit),
        .take     (word_taken)
    );

    assign ser_oe = run && oe && !loop_local;

endmodule

// File: rtl/ecs_framer_chk.sv
module ecs_framer_chk (
    input logic clk,
    input logic rst,
    input logic bit_en,
    input logic awake,
    input logic clk_ready,
    input logic oe,
    input logic loop_local,
    input logic ser_bit,
    input logic ser_oe,
    input logic word_taken
);

    logic rdy_seen;

    always_ff @(posedge clk) begin
        if (rst || !awake) rdy_seen <= 1'b0;
        else if (clk_ready) rdy_seen <= 1'b1;
    end

    a_r1_head_bit: assert property (@(posedge clk) disable iff (rst)
        word_taken |-> ser_bit);

    a_r2_take_on_tick: assert property (@(posedge clk) disable iff (rst)
        word_taken |-> $past(bit_en));

    a_r4_float_asleep: assert property (@(posedge clk) disable iff (rst)
        !awake |-> !ser_oe);

    a_r4_no_take_asleep: assert property (@(posedge clk) disable iff (rst)
        !awake |=> !word_taken);

    a_r5_ready_first: assert property (@(posedge clk) disable iff (rst)
        word_taken |-> rdy_seen);

    a_r6_oe_float: assert property (@(posedge clk) disable iff (rst)
        !oe |-> !ser_oe);

    a_r7_loop_float: assert property (@(posedge clk) disable iff (rst)
        loop_local |-> !ser_oe);

    a_r9_hold_no_tick: assert property (@(posedge clk) disable iff (rst)
        ($past(awake) && !$past(bit_en) && !$past(rst)) |-> $stable(ser_bit));

endmodule

bind ecs_framer ecs_framer_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .bit_en     (bit_en),
    .awake      (awake),
    .clk_ready  (clk_ready),
    .oe         (oe),
    .loop_local (loop_local),
    .ser_bit    (ser_bit),
    .ser_oe     (ser_oe),
    .word_taken (word_taken)
);

// File: tb/ecs_framer_tb.sv
`timescale 1ns/1ps
module ecs_framer_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bit_en = 1'b0;
    logic [17:0] word_in = '0;
    logic        sync_req = 1'b0;
    logic        awake = 1'b0;
    logic        clk_ready = 1'b0;
    logic        oe = 1'b1;
    logic        loop_local = 1'b0;
    logic        ser_bit, ser_oe, word_taken;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    ecs_framer u_dut (
        .clk(clk), .rst(rst), .bit_en(bit_en), .word_in(word_in),
        .sync_req(sync_req), .awake(awake), .clk_ready(clk_ready),
        .oe(oe), .loop_local(loop_local), .ser_bit(ser_bit),
        .ser_oe(ser_oe), .word_taken(word_taken)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // one bit_en pulse; outputs are sampled at the negedge after the edge
    task automatic tick();
        @(negedge clk) bit_en = 1'b1;
        @(negedge clk) bit_en = 1'b0;
    endtask

    function automatic logic [19:0] make_frame(input logic [17:0] w);
        return {1'b0, w, 1'b1};
    endfunction

    // kind: 0 none, 1 oe low in [from,to], 2 loop_local in [from,to],
    // 3 word_in <= alt after bit 'from', 4 idle 8 cycles after bit 'from'
    task automatic recv_frame(input int kind, input int from, input int to,
                              input logic [17:0] alt,
                              output logic [19:0] f, output logic tk);
        logic oe_bad;
        logic hold_bad;
        oe_bad = 1'b0;
        hold_bad = 1'b0;
        tk = 1'b0;
        for (int i = 0; i < 20; i++) begin
            logic exp_oe;
            tick();
            f[i] = ser_bit;
            if (i == 0) tk = word_taken;
            else if (word_taken) tk = 1'b0;
            exp_oe = !((kind == 1 || kind == 2) && i >= from && i <= to);
            if (ser_oe !== exp_oe) oe_bad = 1'b1;
            if (kind == 3 && i == from) word_in = alt;
            if (kind == 4 && i == from) begin
                repeat (8) @(negedge clk);
                if (ser_bit !== f[i]) hold_bad = 1'b1;
            end
            if (kind == 1) oe = !((i + 1) >= from && (i + 1) <= to);
            if (kind == 2) loop_local = ((i + 1) >= from && (i + 1) <= to);
        end
        oe = 1'b1;
        loop_local = 1'b0;
        if (kind == 1) check("R6 ser_oe low only while oe low", {31'd0, oe_bad}, 32'd0);
        else if (kind == 2) check("R7 ser_oe low only in loopback", {31'd0, oe_bad}, 32'd0);
        else check("R6/R7 ser_oe high in normal run", {31'd0, oe_bad}, 32'd0);
        if (kind == 4) check("R9 ser_bit held without bit_en", {31'd0, hold_bad}, 32'd0);
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R8 ser_oe after reset", {31'd0, ser_oe}, 32'd0);
        check("R8 ser_bit after reset", {31'd0, ser_bit}, 32'd0);
        check("R8 word_taken after reset", {31'd0, word_taken}, 32'd0);
    endtask

    task automatic t_wait_ready();
        logic any_take;
        any_take = 1'b0;
        awake = 1'b1;
        for (int i = 0; i < 5; i++) begin
            tick();
            if (word_taken || ser_oe) any_take = 1'b1;
        end
        check("R5 no frame before clk_ready", {31'd0, any_take}, 32'd0);
        clk_ready = 1'b1;
        repeat (3) @(negedge clk);
        check("R5 driving once ready", {31'd0, ser_oe}, 32'd1);
    endtask

    task automatic t_frames();
        logic [17:0] pats [4] = '{18'h3FFFF, 18'h00000, 18'h12345, 18'h2AAAA};
        logic [19:0] f;
        logic tk;
        foreach (pats[k]) begin
            word_in = pats[k];
            recv_frame(0, 0, 0, '0, f, tk);
            check("R1 frame layout", {12'd0, f}, {12'd0, make_frame(pats[k])});
            check("R2 word_taken single pulse at bit 0", {31'd0, tk}, 32'd1);
        end
    endtask

    task automatic t_tear();
        logic [19:0] f;
        logic tk;
        word_in = 18'h0F0F0;
        recv_frame(3, 7, 7, 18'h3C3C3, f, tk);
        check("R2 mid-frame word change ignored", {12'd0, f}, {12'd0, make_frame(18'h0F0F0)});
        recv_frame(0, 0, 0, '0, f, tk);
        check("R2 new word in next frame", {12'd0, f}, {12'd0, make_frame(18'h3C3C3)});
    endtask

    task automatic t_sync();
        logic [19:0] f;
        logic tk;
        int rises;
        word_in = 18'h15555;
        sync_req = 1'b1;
        recv_frame(0, 0, 0, '0, f, tk);
        sync_req = 1'b0;
        check("R3 training frame", {12'd0, f}, {12'd0, make_frame(18'h001FF)});
        rises = 0;
        for (int i = 1; i < 20; i++) if (!f[i-1] && f[i]) rises++;
        check("R3 no rising edge inside training frame", rises, 0);
        recv_frame(0, 0, 0, '0, f, tk);
        check("R3 payload resumes after sync", {12'd0, f}, {12'd0, make_frame(18'h15555)});
    endtask

    task automatic t_float();
        logic [19:0] f;
        logic tk;
        word_in = 18'h2468A;
        recv_frame(1, 5, 9, '0, f, tk);
        check("R6 frame intact across oe low", {12'd0, f}, {12'd0, make_frame(18'h2468A)});
        word_in = 18'h13579;
        recv_frame(2, 2, 15, '0, f, tk);
        check("R7 frame intact across loopback", {12'd0, f}, {12'd0, make_frame(18'h13579)});
        word_in = 18'h2AAAA;
        recv_frame(4, 4, 4, '0, f, tk);
        check("R9 frame intact across stall", {12'd0, f}, {12'd0, make_frame(18'h2AAAA)});
    endtask

    task automatic t_pwrdn();
        logic [19:0] f;
        logic tk;
        logic bad;
        bad = 1'b0;
        word_in = 18'h3F00F;
        for (int i = 0; i < 6; i++) tick();
        @(negedge clk) awake = 1'b0;
        #1;
        check("R4 ser_oe low at once", {31'd0, ser_oe}, 32'd0);
        for (int i = 0; i < 6; i++) begin
            tick();
            if (ser_bit || word_taken || ser_oe) bad = 1'b1;
        end
        check("R4 stopped while asleep", {31'd0, bad}, 32'd0);
        clk_ready = 1'b0;
        @(negedge clk) awake = 1'b1;
        bad = 1'b0;
        for (int i = 0; i < 4; i++) begin
            tick();
            if (word_taken || ser_oe) bad = 1'b1;
        end
        check("R5 held until clk_ready after wake", {31'd0, bad}, 32'd0);
        clk_ready = 1'b1;
        repeat (3) @(negedge clk);
        recv_frame(0, 0, 0, '0, f, tk);
        check("R5 resumes on frame boundary", {12'd0, f}, {12'd0, make_frame(18'h3F00F)});
        check("R5 word_taken on first tick", {31'd0, tk}, 32'd1);
    endtask

    initial begin
        t_reset();
        t_wait_ready();
        t_frames();
        t_tear();
        t_sync();
        t_float();
        t_pwrdn();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #200000;
        checks++;
        fails++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule